// File: doc/BRIEF.md
# Self-Checking Latin-Square Syndrome Generator

This block sits on the read path of a memory protected by a single-error-correcting orthogonal Latin-square code. It takes a 16-bit data word read from storage and the 8 check bits stored with it. It recomputes each check bit from the data, XORs it with the stored check bit, and produces the syndrome. A nonzero syndrome flags an error. A downstream decoder uses the syndrome pattern to find the faulty bit. That decoder is not part of this block.

The data word is viewed as an M x M grid, where data index i sits at row i / M and column i % M. The first M syndrome bits each cover one row of the grid. The last M syndrome bits each cover one column. Every data bit therefore feeds exactly two syndrome bits.

The block also checks its own logic. It produces a two-rail pair: the parity of the stored check bits and the parity of the syndrome bits. The data contributions cancel in the second parity, so the two rails agree whenever the logic is healthy. A single stuck node that changes a syndrome bit makes the rails disagree.

Each syndrome bit is built by its own XOR tree, with no shared gates. All outputs are registered, with a latency of one cycle.

Top module: `ols_syndrome_gen`

## Requirements
- R1: For row r in 0..M-1, syndrome bit r equals stored check bit r XOR the data bits r*M .. r*M+M-1.
- R2: For column c in 0..M-1, syndrome bit M+c equals stored check bit M+c XOR the data bits c, c+M, c+2M, ... .
- R3: For a valid codeword (stored checks equal to the recomputed checks), every syndrome bit and the error flag are 0.
- R4: A single flipped data bit at index i sets exactly syndrome bits i/M and M + i%M.
- R5: A single flipped stored check bit j sets exactly syndrome bit j.
- R6: The error flag equals the OR of all syndrome bits.
- R7: Rail one equals the XOR of the stored check bits. Rail two equals the XOR of the syndrome bits.
- R8: With healthy logic the two rails are equal for every input, whether or not the input is in the code space.
- R9: Under any single stuck-at-0 or stuck-at-1 on a recomputed check node or a syndrome node, each valid or single-error input gives either unequal rails or the correct syndrome.
- R10: Outputs are registered. An input change appears on the outputs after the next rising clock edge. A synchronous active-low reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 16 | Data word read from storage |
| chk_i | input | 8 | Check bits read from storage |
| syn_o | output | 8 | Syndrome: bits 0..3 are rows, bits 4..7 are columns |
| err_o | output | 1 | Error flag, set when any syndrome bit is 1 |
| rail1_o | output | 1 | Parity of the stored check bits |
| rail2_o | output | 1 | Parity of the syndrome bits |

## Verification
Consider a stuck node inside one syndrome tree. If the fault is activated, it shows at the ports one cycle later, and in two ways. The affected syndrome bit differs from the value the bench computes. The two rails also split, because that bit changes the syndrome parity but not the parity of the stored checks.

Now consider a wrong grid mapping, where a data bit is wired into the wrong row or column. A single data-bit error would then set the wrong pair of syndrome bits in the very next sample. The bench therefore checks every single-bit position directly.

// File: rtl/ols_syn_pkg.sv
// Package: sizing helpers shared by the syndrome generator.
// Assumes a single-error-correcting orthogonal Latin-square code, M x M data grid.
package ols_syn_pkg;
    // Number of check bits for single error correction on an M x M grid.
    function automatic int unsigned chk_count(input int unsigned m);
        return 2 * m;
    endfunction
endpackage

// File: rtl/ols_check_slice.sv
// One syndrome bit: an independent XOR tree over the W data bits of one group,
// plus one XOR with the stored check bit. Nothing inside is shared with other slices.
module ols_check_slice #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] grp_i,
    input  logic         chk_i,
    output logic         syn_o
);
    logic par_bit;   // recomputed check bit
    logic syn_bit;   // syndrome node

    // Recompute the check bit from this group's data.
    assign par_bit = ^grp_i;
    // Compare with the stored check bit.
    assign syn_bit = par_bit ^ chk_i;
    assign syn_o   = syn_bit;
endmodule

// File: rtl/ols_rail_pair.sv
// Two-rail checker: parity over the stored check bits and parity over the
// syndrome bits. The trees share no inputs, so a single node fault upsets only one rail.
module ols_rail_pair #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] chk_i,
    input  logic [N-1:0] syn_i,
    output logic         rail1_o,
    output logic         rail2_o
);
    // Rail one: parity of the stored check bits.
    assign rail1_o = ^chk_i;
    // Rail two: parity of the computed syndrome.
    assign rail2_o = ^syn_i;
endmodule

// File: rtl/ols_syndrome_gen.sv
// Top: syndrome generator for an M x M orthogonal Latin-square SEC code, with a
// self-checking two-rail pair. Rows map to syndrome bits 0..M-1, columns to M..2M-1.
// Assumes the stored word lies within one bit of a codeword for the fault-coverage claim.
module ols_syndrome_gen
    import ols_syn_pkg::*;
#(
    parameter int unsigned M = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [M*M-1:0]         data_i,
    input  logic [2*M-1:0]         chk_i,
    output logic [2*M-1:0]         syn_o,
    output logic                   err_o,
    output logic                   rail1_o,
    output logic                   rail2_o
);
    localparam int unsigned K    = M * M;
    localparam int unsigned NCHK = chk_count(M);

    logic [NCHK-1:0] syn_w;
    logic            rail1_w;
    logic            rail2_w;

    // One independent slice per check bit: rows first, then columns.
    for (genvar j = 0; j < NCHK; j++) begin : g_chk
        logic [M-1:0] grp;
        if (j < M) begin : g_row
            assign grp = data_i[j*M +: M];
        end else begin : g_col
            for (genvar i = 0; i < M; i++) begin : g_pick
                assign grp[i] = data_i[i*M + (j - M)];
            end
        end
        ols_check_slice #(.W(M)) i_slice (
            .grp_i (grp),
            .chk_i (chk_i[j]),
            .syn_o (syn_w[j])
        );
    end

    ols_rail_pair #(.N(NCHK)) i_rails (
        .chk_i   (chk_i),
        .syn_i   (syn_w),
        .rail1_o (rail1_w),
        .rail2_o (rail2_w)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_o   <= '0;
            err_o   <= 1'b0;
            rail1_o <= 1'b0;
            rail2_o <= 1'b0;
        end else begin
            syn_o   <= syn_w;
            err_o   <= |syn_w;
            rail1_o <= rail1_w;
            rail2_o <= rail2_w;
        end
    end

    // R10: the first cycle after reset shows cleared outputs.
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (syn_o == '0 && !err_o && !rail1_o && !rail2_o));

    // R6: the error flag agrees with the registered syndrome.
    assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (|syn_o));

    // R7: rail one follows the stored check parity of the previous cycle.
    assert_rail1_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rail1_o == $past(^chk_i)));

    // R7: rail two agrees with the parity of the registered syndrome.
    assert_rail2_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rail2_o == (^syn_o));

    // Parameter sanity: the data width is the grid size.
    initial assert (K == M * M && NCHK == 2 * M);
endmodule

// File: tb/test_ols_syndrome_gen.sv
// Bench: directed corners, random words and a stuck-at campaign on the slice nodes.
module test_ols_syndrome_gen;
    localparam int M = 4;
    localparam int K = M * M;
    localparam int N = 2 * M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [K-1:0] data_i = '0;
    logic [N-1:0] chk_i = '0;
    logic [N-1:0] syn_o;
    logic         err_o, rail1_o, rail2_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ols_syndrome_gen #(.M(M)) i_ols_syndrome_gen (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .chk_i(chk_i),
        .syn_o(syn_o), .err_o(err_o), .rail1_o(rail1_o), .rail2_o(rail2_o)
    );

    // Expected syndrome from the grid definition (rows, then columns).
    function automatic logic [N-1:0] exp_syn(input logic [K-1:0] d, input logic [N-1:0] c);
        logic [N-1:0] s = c;
        for (int i = 0; i < K; i++) begin
            s[i / M]     ^= d[i];
            s[M + i % M] ^= d[i];
        end
        return s;
    endfunction

    function automatic logic [N-1:0] encode(input logic [K-1:0] d);
        return exp_syn(d, '0);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one vector at the falling edge, sample after the next rising edge.
    task automatic apply(input logic [K-1:0] d, input logic [N-1:0] c);
        @(negedge clk);
        data_i = d;
        chk_i  = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input logic [K-1:0] d, input logic [N-1:0] c, input string req);
        logic [N-1:0] e = exp_syn(d, c);
        check(syn_o == e, {req, " syndrome"}, 32'(syn_o), 32'(e));
        check(err_o == (|e), "R6 error flag", 32'(err_o), 32'(|e));
        check(rail1_o == (^c), "R7 rail1", 32'(rail1_o), 32'(^c));
        check(rail2_o == (^e), "R7 rail2", 32'(rail2_o), 32'(^e));
        check(rail1_o == rail2_o, "R8 rails equal", 32'(rail2_o), 32'(rail1_o));
    endtask

    // Stuck-at injection on slice j: node 0 = recomputed check, node 1 = syndrome.
    task automatic fault_set(input int j, input int node, input logic v);
        if (node == 0) begin
            case (j)
                0: force i_ols_syndrome_gen.g_chk[0].i_slice.par_bit = v;
                1: force i_ols_syndrome_gen.g_chk[1].i_slice.par_bit = v;
                2: force i_ols_syndrome_gen.g_chk[2].i_slice.par_bit = v;
                3: force i_ols_syndrome_gen.g_chk[3].i_slice.par_bit = v;
                4: force i_ols_syndrome_gen.g_chk[4].i_slice.par_bit = v;
                5: force i_ols_syndrome_gen.g_chk[5].i_slice.par_bit = v;
                6: force i_ols_syndrome_gen.g_chk[6].i_slice.par_bit = v;
                default: force i_ols_syndrome_gen.g_chk[7].i_slice.par_bit = v;
            endcase
        end else begin
            case (j)
                0: force i_ols_syndrome_gen.g_chk[0].i_slice.syn_bit = v;
                1: force i_ols_syndrome_gen.g_chk[1].i_slice.syn_bit = v;
                2: force i_ols_syndrome_gen.g_chk[2].i_slice.syn_bit = v;
                3: force i_ols_syndrome_gen.g_chk[3].i_slice.syn_bit = v;
                4: force i_ols_syndrome_gen.g_chk[4].i_slice.syn_bit = v;
                5: force i_ols_syndrome_gen.g_chk[5].i_slice.syn_bit = v;
                6: force i_ols_syndrome_gen.g_chk[6].i_slice.syn_bit = v;
                default: force i_ols_syndrome_gen.g_chk[7].i_slice.syn_bit = v;
            endcase
        end
    endtask

    task automatic fault_clear(input int j, input int node);
        if (node == 0) begin
            case (j)
                0: release i_ols_syndrome_gen.g_chk[0].i_slice.par_bit;
                1: release i_ols_syndrome_gen.g_chk[1].i_slice.par_bit;
                2: release i_ols_syndrome_gen.g_chk[2].i_slice.par_bit;
                3: release i_ols_syndrome_gen.g_chk[3].i_slice.par_bit;
                4: release i_ols_syndrome_gen.g_chk[4].i_slice.par_bit;
                5: release i_ols_syndrome_gen.g_chk[5].i_slice.par_bit;
                6: release i_ols_syndrome_gen.g_chk[6].i_slice.par_bit;
                default: release i_ols_syndrome_gen.g_chk[7].i_slice.par_bit;
            endcase
        end else begin
            case (j)
                0: release i_ols_syndrome_gen.g_chk[0].i_slice.syn_bit;
                1: release i_ols_syndrome_gen.g_chk[1].i_slice.syn_bit;
                2: release i_ols_syndrome_gen.g_chk[2].i_slice.syn_bit;
                3: release i_ols_syndrome_gen.g_chk[3].i_slice.syn_bit;
                4: release i_ols_syndrome_gen.g_chk[4].i_slice.syn_bit;
                5: release i_ols_syndrome_gen.g_chk[5].i_slice.syn_bit;
                6: release i_ols_syndrome_gen.g_chk[6].i_slice.syn_bit;
                default: release i_ols_syndrome_gen.g_chk[7].i_slice.syn_bit;
            endcase
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [K-1:0] d;
        logic [N-1:0] c;
        logic [N-1:0] e;
        void'($urandom(32'd1234));

        // R10: reset clears the outputs even with nonzero inputs.
        data_i = 16'hA5C3;
        chk_i  = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(syn_o == '0 && !err_o && !rail1_o && !rail2_o, "R10 reset state",
              {22'd0, syn_o, err_o, rail1_o}, 32'd0);
        rst_n = 1'b1;

        // R10: one-cycle latency - before the edge the old value still shows.
        apply(16'h0000, 8'h00);
        @(negedge clk);
        data_i = 16'h0001;
        chk_i  = 8'h00;
        #1;
        check(syn_o == 8'h00, "R10 held before edge", 32'(syn_o), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check(syn_o == 8'h11, "R10 updated after edge", 32'(syn_o), 32'h11);

        // R1 R2: directed rows and columns.
        apply(16'h000F, 8'h00);
        check_all(16'h000F, 8'h00, "R1 row0 all ones");
        apply(16'h1111, 8'h00);
        check_all(16'h1111, 8'h00, "R2 column0 all ones");
        apply(16'hFFFF, 8'hFF);
        check_all(16'hFFFF, 8'hFF, "R1 R2 all ones");

        // R3: valid codewords.
        for (int n = 0; n < 20; n++) begin
            d = 16'($urandom);
            c = encode(d);
            apply(d, c);
            check(syn_o == '0 && !err_o, "R3 valid codeword", 32'(syn_o), 32'h0);
        end

        // R4: every single data-bit position.
        for (int i = 0; i < K; i++) begin
            d = 16'($urandom);
            c = encode(d);
            d[i] = ~d[i];
            apply(d, c);
            e = '0;
            e[i / M] = 1'b1;
            e[M + i % M] = 1'b1;
            check(syn_o == e, "R4 single data error", 32'(syn_o), 32'(e));
        end

        // R5: every single check-bit position.
        for (int j = 0; j < N; j++) begin
            d = 16'($urandom);
            c = encode(d);
            c[j] = ~c[j];
            apply(d, c);
            e = '0;
            e[j] = 1'b1;
            check(syn_o == e, "R5 single check error", 32'(syn_o), 32'(e));
            check(err_o, "R6 flag on check error", 32'(err_o), 32'h1);
        end

        // R1 R2 R6 R7 R8: arbitrary words, in and out of the code space.
        for (int n = 0; n < 200; n++) begin
            d = 16'($urandom);
            c = 8'($urandom);
            apply(d, c);
            check_all(d, c, "R1 R2 random");
        end

        // R9: stuck-at campaign on every slice node, both polarities.
        for (int j = 0; j < N; j++) begin
            for (int node = 0; node < 2; node++) begin
                for (int v = 0; v < 2; v++) begin
                    fault_set(j, node, v[0]);
                    for (int n = 0; n < 12; n++) begin
                        int sel;
                        d = 16'($urandom);
                        c = encode(d);
                        sel = int'($urandom % 25);
                        if (sel < K) d[sel] = ~d[sel];
                        else if (sel < K + N) c[sel - K] = ~c[sel - K];
                        apply(d, c);
                        e = exp_syn(d, c);
                        check((rail1_o != rail2_o) || (syn_o == e), "R9 stuck-at detected",
                              32'(syn_o), 32'(e));
                    end
                    fault_clear(j, node);
                end
            end
        end

        // After release the logic is healthy again.
        apply(16'h8001, 8'h00);
        check_all(16'h8001, 8'h00, "R1 R2 after release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule